// File: doc/BRIEF.md
# Cross-Chip Port Membership Table

This block keeps, for every source device and source port in a stack of switch chips, a vector that lists which local ports a frame from that source may reach. The table has 512 entries of 11 bits. It is not mapped into the host address space directly. The host sees two 16-bit registers: a data register and a command register.

To write an entry, the host first loads the vector into the data register. It then writes the command register with the busy bit set, a write opcode and a 9-bit pointer. To read an entry, the host writes the command register with a read opcode. The block then copies the stored vector into the data register.

Each operation holds busy for a fixed two cycles and then clears it. The host polls busy and must see it clear before it issues the next register write. A mode input selects the pointer layout. Only the layout with a 5-bit device and a 4-bit port is served. While the other layout is selected, commands are refused.

Top module: `xchip_member_table`

## Requirements
- R1: After reset, every entry holds all-ones (0x7FF), the data register reads 0x0000 and the command register reads 0x0000.
- R2: The pointer is command bits 8:0, with the source device in bits 8:4 and the source port in bits 3:0. Entry index = device*16 + port, so pointers that differ only by a swapped device/port value reach different entries.
- R3: A command starts only when the host writes the command register (select = 1) with bit 15 set. The command register then reads back bit 15 = 1, the opcode (bits 14:12) and the pointer (bits 8:0). Bits 11:9 read as zero.
- R4: Busy reads 1 on the two cycles after the command-write edge and 0 from the third cycle on.
- R5: Opcode 3 stores data-register bits 10:0 into the addressed entry. Data bits 15:11 are dropped.
- R6: Opcode 4 loads the addressed entry, zero-extended to 16 bits, into the data register by the cycle in which busy reads 0.
- R7: A command-register write while busy is set has no effect. Busy timing, opcode, pointer and table contents stay as set by the running operation.
- R8: A data-register write while busy is set has no effect.
- R9: A command-register write with bit 15 clear changes nothing. An opcode other than 3 or 4 runs the normal busy sequence but changes neither the table nor the data register.
- R10: While the wide-port mode input is 1, command-register writes are refused: busy stays 0 and the table is unchanged.
- R11: When idle, the data register reads back the full 16-bit value last written to it (select = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_port_mode_i | input | 1 | 1 selects the unsupported 5-bit-port pointer layout (commands refused) |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 1 | Register select: 0 data, 1 command |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Read data of the selected register |

## Verification
Writes and reads use several pointer patterns:
- A device-only pointer and a port-only pointer holding the same number: a swapped or mis-shifted field decode would merge them.
- The extreme indices 0 and 511.
- An untouched neighbour entry: this exposes a stray write.

The vectors are alternating-bit, all-zero, and values with high data bits set, which exposes truncation mistakes. Busy is sampled on each cycle of an operation, and register writes are driven at each busy phase, to show whether a blocked write leaks into the pointer, the opcode or the data.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
    localparam int DEV_W    = 5;
    localparam int PORT_W   = 4;
    localparam int PTR_W    = DEV_W + PORT_W;
    localparam int VEC_W    = 11;
    localparam int REG_W    = 16;
    localparam int OP_W     = 3;
    localparam int BUSY_BIT = REG_W - 1;
    localparam int OP_LSB   = BUSY_BIT - OP_W;
    localparam int PAD_W    = OP_LSB - PTR_W;

    localparam logic [OP_W-1:0] OP_WRVEC = 3'd3;
    localparam logic [OP_W-1:0] OP_RDVEC = 3'd4;

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [OP_W-1:0]   op;
        logic [PTR_W-1:0]  ptr;
        logic [REG_W-1:0]  data;
    } ctrl_t;
endpackage

// File: rtl/xcm_ptr_decode.sv
module xcm_ptr_decode #(
    parameter int DEV_W  = xcm_pkg::DEV_W,
    parameter int PORT_W = xcm_pkg::PORT_W,
    localparam int PTR_W = DEV_W + PORT_W
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             wide_port_mode_i,
    output logic [PTR_W-1:0] idx_o,
    output logic             ok_o
);
    logic [DEV_W-1:0]  src_dev;
    logic [PORT_W-1:0] src_port;

    // narrow-port layout: device in the upper field, port in the lower
    always_comb begin
        src_dev  = ptr_i[PTR_W-1 -: DEV_W];
        src_port = ptr_i[PORT_W-1:0];
        idx_o    = {src_dev, src_port};
        ok_o     = !wide_port_mode_i;
    end
endmodule

// File: rtl/xcm_store.sv
module xcm_store #(
    parameter int VEC_W = xcm_pkg::VEC_W,
    parameter int IDX_W = xcm_pkg::PTR_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [VEC_W-1:0] wvec_i,
    output logic [VEC_W-1:0] rvec_o
);
    logic [VEC_W-1:0] vec_q [DEPTH];
    logic [VEC_W-1:0] vec_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign vec_d[g] = (we_i && (idx_i == IDX_W'(g))) ? wvec_i : vec_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) vec_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) vec_q[i] <= vec_d[i];
        end
    end

    assign rvec_o = vec_q[idx_i];

    // R5: a write lands in the addressed row
    a_r5_row_written: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> vec_q[$past(idx_i)] == $past(wvec_i));
endmodule

// File: rtl/xcm_ctrl.sv
module xcm_ctrl
    import xcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_port_mode_i,
    input  logic              host_we_i,
    input  logic              host_sel_i,
    input  logic [REG_W-1:0]  host_wdata_i,
    output logic [REG_W-1:0]  host_rdata_o,
    output logic [PTR_W-1:0]  ptr_o,
    input  logic              ptr_ok_i,
    input  logic [VEC_W-1:0]  rvec_i,
    output logic              mem_we_o,
    output logic [VEC_W-1:0]  wvec_o
);
    ctrl_t cur_q, nxt_d;
    logic  cmd_wr, dat_wr;
    logic  unused_pad;

    assign cmd_wr     = host_we_i && host_sel_i;
    assign dat_wr     = host_we_i && !host_sel_i;
    assign unused_pad = ^host_wdata_i[OP_LSB-1:PTR_W];

    always_comb begin
        nxt_d    = cur_q;
        mem_we_o = 1'b0;
        if (!cur_q.busy) begin
            if (dat_wr) nxt_d.data = host_wdata_i;
            if (cmd_wr && host_wdata_i[BUSY_BIT] && !wide_port_mode_i) begin
                nxt_d.busy  = 1'b1;
                nxt_d.phase = 1'b0;
                nxt_d.op    = host_wdata_i[OP_LSB +: OP_W];
                nxt_d.ptr   = host_wdata_i[PTR_W-1:0];
            end
        end else if (!cur_q.phase) begin
            nxt_d.phase = 1'b1;
        end else begin
            nxt_d.busy  = 1'b0;
            nxt_d.phase = 1'b0;
            if (ptr_ok_i && cur_q.op == OP_WRVEC) mem_we_o = 1'b1;
            if (ptr_ok_i && cur_q.op == OP_RDVEC)
                nxt_d.data = {{(REG_W-VEC_W){1'b0}}, rvec_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ptr_o  = cur_q.ptr;
    assign wvec_o = cur_q.data[VEC_W-1:0];
    assign host_rdata_o = host_sel_i
        ? {cur_q.busy, cur_q.op, {PAD_W{1'b0}}, cur_q.ptr}
        : cur_q.data;

    // R4: busy lasts two cycles
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.busy) |=> cur_q.busy);
    a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && cur_q.phase) |=> !cur_q.busy);
    // R7: command fields frozen while busy
    a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && cmd_wr) |=> ($stable(cur_q.ptr) && $stable(cur_q.op)));
    // R8: data register frozen in the first busy cycle
    a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.busy && !cur_q.phase) |=> $stable(cur_q.data));
    // R10: wide-port mode refuses commands
    a_r10_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.busy && wide_port_mode_i) |=> !cur_q.busy);
endmodule

// File: rtl/xchip_member_table.sv
module xchip_member_table
    import xcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_port_mode_i,
    input  logic              host_we_i,
    input  logic              host_sel_i,
    input  logic [REG_W-1:0]  host_wdata_i,
    output logic [REG_W-1:0]  host_rdata_o
);
    logic [PTR_W-1:0] ptr, idx;
    logic             ptr_ok, mem_we;
    logic [VEC_W-1:0] rvec, wvec;

    xcm_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wide_port_mode_i(wide_port_mode_i),
        .host_we_i(host_we_i), .host_sel_i(host_sel_i),
        .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
        .ptr_o(ptr), .ptr_ok_i(ptr_ok), .rvec_i(rvec),
        .mem_we_o(mem_we), .wvec_o(wvec)
    );

    xcm_ptr_decode #(.DEV_W(DEV_W), .PORT_W(PORT_W)) i_decode (
        .ptr_i(ptr), .wide_port_mode_i(wide_port_mode_i),
        .idx_o(idx), .ok_o(ptr_ok)
    );

    xcm_store #(.VEC_W(VEC_W), .IDX_W(PTR_W)) i_store (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .idx_i(idx),
        .wvec_i(wvec), .rvec_o(rvec)
    );
endmodule

// File: tb/test_xchip_member_table.sv
module test_xchip_member_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    xchip_member_table i_xchip_member_table (
        .clk(clk), .rst_n(rst_n), .wide_port_mode_i(mode),
        .host_we_i(we), .host_sel_i(sel), .host_wdata_i(wdata),
        .host_rdata_o(rdata)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the next falling edge
    task automatic wr_reg(logic s, logic [15:0] v);
        we = 1'b1; sel = s; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_reg(logic s, output logic [15:0] v);
        sel = s;
        #1 v = rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_reg(1'b1, v);
            if (!v[15]) return;
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] cmd(logic [2:0] op, logic [8:0] p);
        return {1'b1, op, 3'b000, p};
    endfunction

    task automatic put(logic [8:0] p, logic [15:0] v);
        wr_reg(1'b0, v);
        wr_reg(1'b1, cmd(3'd3, p));
        wait_idle();
    endtask

    task automatic get(logic [8:0] p, output logic [15:0] v);
        wr_reg(1'b1, cmd(3'd4, p));
        wait_idle();
        rd_reg(1'b0, v);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd_reg(1'b0, v); chk("R1 data after reset", v, 16'h0000);
        rd_reg(1'b1, v); chk("R1 cmd after reset", v, 16'h0000);
        get(9'd0, v);    chk("R1 entry 0 reset", v, 16'h07FF);
        get(9'd511, v);  chk("R1 entry 511 reset", v, 16'h07FF);
    endtask

    task automatic t_latency();
        logic [15:0] v;
        wr_reg(1'b1, cmd(3'd4, 9'h0A5));
        rd_reg(1'b1, v); chk("R3 cmd readback while busy", v, 16'hC0A5);
        @(negedge clk);
        rd_reg(1'b1, v); chk("R4 busy second cycle", {15'd0, v[15]}, 16'd1);
        @(negedge clk);
        rd_reg(1'b1, v); chk("R4 busy clear third cycle", {15'd0, v[15]}, 16'd0);
    endtask

    task automatic t_decode();
        logic [15:0] v;
        put(9'h010, 16'h0555);   // device 1 port 0
        put(9'h001, 16'h02AA);   // device 0 port 1
        get(9'h010, v); chk("R2 device-only pointer", v, 16'h0555);
        get(9'h001, v); chk("R2 port-only pointer", v, 16'h02AA);
        get(9'h011, v); chk("R2 neighbour untouched", v, 16'h07FF);
        put(9'h1FF, 16'hF000);
        get(9'h1FF, v); chk("R5 top entry zero vector", v, 16'h0000);
        put(9'h000, 16'hFB6D);
        get(9'h000, v); chk("R5 R6 high data bits dropped", v, 16'h036D);
    endtask

    task automatic t_cmd_busy();
        logic [15:0] v;
        wr_reg(1'b0, 16'h0123);
        wr_reg(1'b1, cmd(3'd3, 9'h042));
        wr_reg(1'b1, cmd(3'd4, 9'h043));   // lands while busy
        rd_reg(1'b1, v); chk("R7 busy from first op only", v, 16'hB042);
        @(negedge clk);
        rd_reg(1'b1, v); chk("R7 no second operation", v, 16'h3042);
        rd_reg(1'b0, v); chk("R7 data untouched by ignored read", v, 16'h0123);
        get(9'h042, v);  chk("R7 first write stored", v, 16'h0123);
    endtask

    task automatic t_data_busy();
        logic [15:0] v;
        wr_reg(1'b0, 16'h0321);
        wr_reg(1'b1, cmd(3'd3, 9'h077));
        wr_reg(1'b0, 16'h0456);             // lands while busy
        wait_idle();
        rd_reg(1'b0, v); chk("R8 data kept during busy", v, 16'h0321);
        get(9'h077, v);  chk("R8 entry got pre-busy data", v, 16'h0321);
    endtask

    task automatic t_nop();
        logic [15:0] v;
        wr_reg(1'b0, 16'h0111);
        wr_reg(1'b1, 16'h3005);             // bit 15 clear
        rd_reg(1'b1, v); chk("R9 no-busy command ignored", v, 16'h4077);
        wr_reg(1'b1, cmd(3'd1, 9'h005));
        rd_reg(1'b1, v); chk("R9 other opcode busy", {15'd0, v[15]}, 16'd1);
        wait_idle();
        rd_reg(1'b0, v); chk("R9 other opcode keeps data", v, 16'h0111);
        get(9'h005, v);  chk("R9 entry unchanged", v, 16'h07FF);
    endtask

    task automatic t_mode();
        logic [15:0] v;
        wr_reg(1'b0, 16'h0000);
        mode = 1'b1;
        wr_reg(1'b1, cmd(3'd3, 9'h100));
        rd_reg(1'b1, v); chk("R10 refused while wide mode", {15'd0, v[15]}, 16'd0);
        mode = 1'b0;
        get(9'h100, v);  chk("R10 entry unchanged", v, 16'h07FF);
    endtask

    task automatic t_data_reg();
        logic [15:0] v;
        wr_reg(1'b0, 16'hBEEF);
        rd_reg(1'b0, v); chk("R11 data readback", v, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_decode();
        t_cmd_busy();
        t_data_busy();
        t_nop();
        t_mode();
        t_data_reg();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0x0000 expected 0x0001");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule